// File: doc/BRIEF.md
# Operand Bypass Selector with Write-Through Register File

This block resolves read-after-write dependences for the two ALU operands of a five-stage in-order pipeline. For each source register index held by the instruction now in the execute stage, it looks at the destination index and write flag of the two older instructions still in flight. The older one has just finished execute and the oldest is waiting to write back. From these it produces a 2-bit select per operand. The select tells the operand multiplexer to take the register-file value, the write-back result or the freshly computed execute result. When both in-flight instructions target the same register, the younger one wins. Index zero is the constant-zero register and is never bypassed.

The same block holds the architectural register file. It has two combinational read ports and one write port that updates on the rising clock edge. A read that names the register being written in that same cycle returns the incoming write data, so the decode stage never sees a stale value from the write-back stage. Register zero ignores writes and always reads as zero. The block is used by wiring the execute-stage source indices and the two pipeline-register destination fields to the selector. The write-back bus goes to the write port, and the decode-stage indices go to the read ports.

Top module: `bypass_unit`

## Requirements
- R1: `fwdSelA` is 2'b10 (take the execute-stage result) when `memRegWr` is 1, `memRd` is nonzero and `memRd` equals `exRs`.
- R2: `fwdSelA` is 2'b01 (take the write-back result) when `wbRegWr` is 1, `wbRd` is nonzero and `wbRd` equals `exRs`, and the R1 condition does not hold.
- R3: When the R1 and R2 conditions hold together for an operand, the select is 2'b10. The younger result has priority.
- R4: A source index of zero always yields select 2'b00, whatever the destination indices and write flags are.
- R5: Select 2'b00 (register-file value) is produced when neither in-flight destination matches the source index, or when the matching entry has its write flag clear.
- R6: `fwdSelB` follows rules R1 to R5 using `exRt` in place of `exRs`, independently of `fwdSelA`.
- R7: With `wrEn` at 1 and `wrAddr` nonzero, `wrData` is stored into register `wrAddr` at the rising clock edge. From the next cycle onward, a read of that index returns the stored value.
- R8: In a cycle where `wrEn` is 1 and `wrAddr` is nonzero, a read port whose index equals `wrAddr` returns `wrData` in that same cycle.
- R9: Reading index zero returns 0 on either port. A write to index zero has no effect, either in the same cycle or afterwards.
- R10: While `rstN` is low, all registers are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| exRs | input | 5 | First source index of the execute-stage instruction |
| exRt | input | 5 | Second source index of the execute-stage instruction |
| memRd | input | 5 | Destination index held after execute |
| memRegWr | input | 1 | Write flag held after execute |
| wbRd | input | 5 | Destination index held before write-back |
| wbRegWr | input | 1 | Write flag held before write-back |
| fwdSelA | output | 2 | Operand A select: 00 file, 01 write-back, 10 execute result |
| fwdSelB | output | 2 | Operand B select, same encoding |
| rdAddrA | input | 5 | Read port A index |
| rdAddrB | input | 5 | Read port B index |
| rdDataA | output | DATA_W | Read port A data |
| rdDataB | output | DATA_W | Read port B data |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Write index |
| wrData | input | DATA_W | Write data |

## Verification
The selects and both read ports are combinational, so their results are due in the same cycle as the stimulus. The bench applies inputs on the falling edge and samples a few nanoseconds later, before the next rising edge. A stored write is due only after one rising edge. Write tests therefore drive the write on a falling edge, let one rising edge pass, drop the enable and check the read on the following falling-edge window. The same-cycle write-through and zero-register cases are checked before that edge, and again after it.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  localparam int REG_IDX_W = 5;

  typedef logic [REG_IDX_W-1:0] regIdx_t;

  typedef enum logic [1:0] {
    SEL_FILE = 2'b00,
    SEL_WB   = 2'b01,
    SEL_MEM  = 2'b10
  } fwdSel_t;

  // strobe from control to datapath: a qualified register write
  typedef struct packed {
    logic    commit;
    regIdx_t dest;
  } wrStrobe_t;
endpackage

// File: rtl/bypass_pick.sv
module bypass_pick
  import bypass_pkg::*;
(
  input  regIdx_t    srcIdx,
  input  regIdx_t    memDest,
  input  logic       memWr,
  input  regIdx_t    wbDest,
  input  logic       wbWr,
  output logic [1:0] sel
);
  logic    srcLive;
  logic    memHit;
  logic    wbHit;
  fwdSel_t choice;

  always_comb begin
    srcLive = (srcIdx != '0);
    memHit  = memWr && srcLive && (memDest == srcIdx);
    wbHit   = wbWr && srcLive && (wbDest == srcIdx);
    if (memHit)     choice = SEL_MEM;
    else if (wbHit) choice = SEL_WB;
    else            choice = SEL_FILE;
  end

  assign sel = choice;
endmodule

// File: rtl/bypass_ctrl.sv
module bypass_ctrl
  import bypass_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  regIdx_t [NUM_SRC-1:0]     srcIdx,
  input  regIdx_t                   memDest,
  input  logic                      memWr,
  input  regIdx_t                   wbDest,
  input  logic                      wbWr,
  input  logic                      wrEn,
  input  regIdx_t                   wrAddr,
  output logic [NUM_SRC-1:0][1:0]   selVec,
  output wrStrobe_t                 strobe
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pick
    bypass_pick u_pick (
      .srcIdx (srcIdx[g]),
      .memDest(memDest),
      .memWr  (memWr),
      .wbDest (wbDest),
      .wbWr   (wbWr),
      .sel    (selVec[g])
    );
  end

  always_comb begin
    strobe.commit = wrEn && (wrAddr != '0);
    strobe.dest   = wrAddr;
  end
endmodule

// File: rtl/regfile_wt.sv
module regfile_wt
  import bypass_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_RD = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  wrStrobe_t                      strobe,
  input  logic [DATA_W-1:0]              wrData,
  input  regIdx_t [NUM_RD-1:0]           rdIdx,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdData
);
  localparam int NUM_REGS = 1 << REG_IDX_W;

  logic [DATA_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (strobe.commit) begin
      regs[strobe.dest] <= wrData;
    end
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : g_port
    always_comb begin
      if (rdIdx[g] == '0)
        rdData[g] = '0;
      else if (strobe.commit && (strobe.dest == rdIdx[g]))
        rdData[g] = wrData;
      else
        rdData[g] = regs[rdIdx[g]];
    end
  end
endmodule

// File: rtl/bypass_unit.sv
module bypass_unit
  import bypass_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        exRs,
  input  logic [4:0]        exRt,
  input  logic [4:0]        memRd,
  input  logic              memRegWr,
  input  logic [4:0]        wbRd,
  input  logic              wbRegWr,
  output logic [1:0]        fwdSelA,
  output logic [1:0]        fwdSelB,
  input  logic [4:0]        rdAddrA,
  input  logic [4:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [4:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData
);
  localparam int NUM_SRC = 2;

  regIdx_t [NUM_SRC-1:0]            srcIdx;
  logic    [NUM_SRC-1:0][1:0]       selVec;
  regIdx_t [NUM_SRC-1:0]            rdIdx;
  logic    [NUM_SRC-1:0][DATA_W-1:0] rdVec;
  wrStrobe_t                        strobe;

  assign srcIdx = {exRt, exRs};
  assign rdIdx  = {rdAddrB, rdAddrA};

  bypass_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .srcIdx (srcIdx),
    .memDest(memRd),
    .memWr  (memRegWr),
    .wbDest (wbRd),
    .wbWr   (wbRegWr),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .selVec (selVec),
    .strobe (strobe)
  );

  regfile_wt #(.DATA_W(DATA_W), .NUM_RD(NUM_SRC)) u_rf (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(wrData),
    .rdIdx (rdIdx),
    .rdData(rdVec)
  );

  assign fwdSelA = selVec[0];
  assign fwdSelB = selVec[1];
  assign rdDataA = rdVec[0];
  assign rdDataB = rdVec[1];
endmodule

// File: rtl/bypass_unit_chk.sv
module bypass_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [4:0]        exRs,
  input logic [4:0]        exRt,
  input logic [4:0]        memRd,
  input logic              memRegWr,
  input logic [4:0]        wbRd,
  input logic              wbRegWr,
  input logic [1:0]        fwdSelA,
  input logic [1:0]        fwdSelB,
  input logic [4:0]        rdAddrA,
  input logic [4:0]        rdAddrB,
  input logic [DATA_W-1:0] rdDataA,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [4:0]        wrAddr,
  input logic [DATA_W-1:0] wrData
);
  logic memA, memB, wbA, wbB;
  assign memA = memRegWr && memRd != 5'd0 && memRd == exRs;
  assign memB = memRegWr && memRd != 5'd0 && memRd == exRt;
  assign wbA  = wbRegWr && wbRd != 5'd0 && wbRd == exRs;
  assign wbB  = wbRegWr && wbRd != 5'd0 && wbRd == exRt;

  AST_MEM_WINS_A: assert property (@(posedge clk) disable iff (!rstN) memA |-> fwdSelA == 2'b10); // R1
  AST_WB_PICK_A: assert property (@(posedge clk) disable iff (!rstN) (wbA && !memA) |-> fwdSelA == 2'b01); // R2
  AST_BOTH_HIT_B: assert property (@(posedge clk) disable iff (!rstN) (memB && wbB) |-> fwdSelB == 2'b10); // R3
  AST_ZERO_SRC_A: assert property (@(posedge clk) disable iff (!rstN) (exRs == 5'd0) |-> fwdSelA == 2'b00); // R4
  AST_ZERO_SRC_B: assert property (@(posedge clk) disable iff (!rstN) (exRt == 5'd0) |-> fwdSelB == 2'b00); // R4
  AST_NO_HIT_B: assert property (@(posedge clk) disable iff (!rstN) (!memB && !wbB) |-> fwdSelB == 2'b00); // R5
  AST_WB_PICK_B: assert property (@(posedge clk) disable iff (!rstN) (wbB && !memB) |-> fwdSelB == 2'b01); // R6
  AST_STORED_A: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != 5'd0) |=>
      ((rdAddrA != $past(wrAddr)) || (wrEn && wrAddr == rdAddrA) || (rdDataA == $past(wrData)))); // R7
  AST_THROUGH_A: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != 5'd0 && rdAddrA == wrAddr) |-> rdDataA == wrData); // R8
  AST_THROUGH_B: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != 5'd0 && rdAddrB == wrAddr) |-> rdDataB == wrData); // R8
  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == 5'd0) |-> rdDataA == '0); // R9
endmodule

bind bypass_unit bypass_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_bypass_unit.sv
`timescale 1ns/1ps
module tb_bypass_unit;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [4:0]        exRs = '0, exRt = '0, memRd = '0, wbRd = '0;
  logic              memRegWr = 1'b0, wbRegWr = 1'b0;
  logic [1:0]        fwdSelA, fwdSelB;
  logic [4:0]        rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [DATA_W-1:0] rdDataA, rdDataB, wrData = '0;
  logic              wrEn = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bypass_unit #(.DATA_W(DATA_W)) dut (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic setFwd(logic [4:0] rs, logic [4:0] rt, logic [4:0] md, logic mw,
                        logic [4:0] wd, logic ww);
    @(negedge clk);
    exRs = rs; exRt = rt; memRd = md; memRegWr = mw; wbRd = wd; wbRegWr = ww;
    #2;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rdAddrA = 5'd5; rdAddrB = 5'd31;
    #2;
    check("R10 read r5 after reset", rdDataA, 32'h0);
    check("R10 read r31 after reset", rdDataB, 32'h0);
  endtask

  task automatic t_mem_fwd();
    setFwd(5'd3, 5'd4, 5'd3, 1'b1, 5'd0, 1'b0);
    check("R1 selA from execute result", {30'd0, fwdSelA}, 32'd2);
    check("R5 selB no match", {30'd0, fwdSelB}, 32'd0);
  endtask

  task automatic t_wb_fwd();
    setFwd(5'd7, 5'd8, 5'd2, 1'b1, 5'd7, 1'b1);
    check("R2 selA from write-back", {30'd0, fwdSelA}, 32'd1);
  endtask

  task automatic t_priority();
    setFwd(5'd9, 5'd9, 5'd9, 1'b1, 5'd9, 1'b1);
    check("R3 selA younger wins", {30'd0, fwdSelA}, 32'd2);
    check("R3 selB younger wins", {30'd0, fwdSelB}, 32'd2);
  endtask

  task automatic t_zero();
    setFwd(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
    check("R4 selA zero source", {30'd0, fwdSelA}, 32'd0);
    check("R4 selB zero source", {30'd0, fwdSelB}, 32'd0);
  endtask

  task automatic t_no_write();
    setFwd(5'd11, 5'd11, 5'd11, 1'b0, 5'd11, 1'b0);
    check("R5 selA flags clear", {30'd0, fwdSelA}, 32'd0);
    setFwd(5'd11, 5'd12, 5'd13, 1'b1, 5'd14, 1'b1);
    check("R5 selA index mismatch", {30'd0, fwdSelA}, 32'd0);
    check("R5 selB index mismatch", {30'd0, fwdSelB}, 32'd0);
  endtask

  task automatic t_b_side();
    setFwd(5'd13, 5'd12, 5'd12, 1'b1, 5'd13, 1'b1);
    check("R6 selA write-back", {30'd0, fwdSelA}, 32'd1);
    check("R6 selB execute result", {30'd0, fwdSelB}, 32'd2);
    setFwd(5'd20, 5'd21, 5'd20, 1'b1, 5'd21, 1'b1);
    check("R6 selB write-back", {30'd0, fwdSelB}, 32'd1);
  endtask

  task automatic t_write_read();
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd6; wrData = 32'hDEADBEEF;
    rdAddrA = 5'd7; rdAddrB = 5'd7;
    @(negedge clk);
    wrEn = 1'b0; rdAddrA = 5'd6;
    #2;
    check("R7 stored value next cycle", rdDataA, 32'hDEADBEEF);
    check("R7 other register untouched", rdDataB, 32'h0);
  endtask

  task automatic t_write_through();
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd10; wrData = 32'h00001234;
    rdAddrA = 5'd10; rdAddrB = 5'd10;
    #2;
    check("R8 port A same-cycle data", rdDataA, 32'h00001234);
    check("R8 port B same-cycle data", rdDataB, 32'h00001234);
    @(negedge clk);
    wrData = 32'h0000ABCD;
    #2;
    check("R8 rewrite same cycle", rdDataA, 32'h0000ABCD);
    @(negedge clk);
    wrEn = 1'b0;
    #2;
    check("R7 last write kept", rdDataB, 32'h0000ABCD);
  endtask

  task automatic t_zero_reg();
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd0; wrData = 32'hFFFFFFFF;
    rdAddrA = 5'd0; rdAddrB = 5'd0;
    #2;
    check("R9 zero reg same cycle", rdDataA, 32'h0);
    @(negedge clk);
    wrEn = 1'b0;
    #2;
    check("R9 zero reg after write", rdDataB, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_mem_fwd();
    t_wb_fwd();
    t_priority();
    t_zero();
    t_no_write();
    t_b_side();
    t_write_read();
    t_write_through();
    t_zero_reg();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule